// File: doc/BRIEF.md
# Daisy-Chain Serial Link Master

This block is the only initiator on a single-wire, daisy-chained command/response link. A local register-side request names a slave ID, a kind of access (read, write or status) and, for memory accesses, a 24-bit address and an 8-bit write byte. The block splits the request into one or more transfer cycles. In each cycle it serializes one 16-bit command frame with a 5-bit CRC, waits for the single 16-bit reply, checks the reply's CRC and stop bit, and then either moves to the next frame or finishes.

A memory access costs up to four cycles: high address byte, middle address byte, low address byte, then the data frame. The block remembers the slave and the upper 16 address bits of the last successful memory access. When a new access matches them, only the low-address frame and the data frame are sent, so a nearby access completes in two cycles. Every good reply also carries a return-path interrupt flag, which any slave on the way back may have set. The block exposes that flag as an interrupt request. Corrupted replies, and missing replies, abort the request and set sticky error flags.

Top module: `dclink_master`

## Requirements
- R1: A frame on the line is a start bit (0), 16 word bits MSB first, 5 CRC bits MSB first, then a stop bit (1). `txLine` idles high. The command word is {opcode[15:13], slave ID[12:9], payload[8:0]}.
- R2: The CRC uses polynomial x^5+x^2+1 (taps 5'h05) with an all-ones initial value. It is shifted MSB first over the 16 word bits, with no final inversion.
- R3: Every bit on the line lasts `clkDiv`+1 clock cycles, with `clkDiv` of 3 or more.
- R4: A read or write with no address reuse sends four frames in this order: opcode 1 with payload {0,addr[23:16]}, opcode 2 with {0,addr[15:8]}, opcode 2 with {1,addr[7:0]}, and then either opcode 3 with {0,wrData} (write) or opcode 4 with payload 0 (read).
- R5: If the last successful read or write went to the same slave with the same addr[23:8], the block sends only the low-address frame and the data frame.
- R6: A status request (`reqKind` 2 or 3) sends one frame, opcode 5 with payload 0, and leaves the address reuse state unchanged.
- R7: A reply word is {irq[15], reserved[14:8], data[7:0]}. After the final reply of a successful read or status request, `rdData` shows data[7:0]. Writes and failed requests leave `rdData` unchanged.
- R8: `irqPending` takes bit 15 of every reply that passes its checks. A reply that fails its checks does not change it.
- R9: A reply with a bad CRC or a stop bit of 0 is discarded. The request ends with `xferOk`=0, sticky `errCrc` is set, and address reuse is cleared.
- R10: If no start bit arrives within 32 bit times after a command frame ends, the request ends with `xferOk`=0 and sticky `errTimeout` is set. The block makes no retry and clears address reuse.
- R11: `errClear` clears both sticky flags on the next edge.
- R12: `reqStart` is ignored while `busy` is high. `done` is a one-cycle pulse, and `xferOk` is valid with it.
- R13: After reset, `txLine` is 1, `busy`, `done`, `errCrc`, `errTimeout` and `irqPending` are 0, and `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkDiv | input | 16 | Bit period minus one, in clocks |
| reqStart | input | 1 | Start a request (ignored while busy) |
| reqKind | input | 2 | 0 read, 1 write, 2/3 status |
| reqSlave | input | 4 | Target slave ID |
| reqAddr | input | 24 | Slave memory address |
| reqWrData | input | 8 | Byte to write |
| errClear | input | 1 | Clear sticky error flags |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one cycle) |
| xferOk | output | 1 | Finished request succeeded |
| rdData | output | 8 | Last read/status data |
| errCrc | output | 1 | Sticky reply integrity error |
| errTimeout | output | 1 | Sticky missing-reply error |
| irqPending | output | 1 | Interrupt flag of last good reply |
| txLine | output | 1 | Serial command line |
| rxLine | input | 1 | Serial reply line |

## Verification
Wrong address reuse state shows up at once as a wrong frame count, or as a wrong opcode in the very next request. This is why each request's decoded command frames are compared word by word against a model of the reuse rule. A bit counter or divider that slips shows up within one frame as a CRC mismatch at the bench's slave, or as a start bit of the wrong length. A fault in the reply checker shows up in the same `done` cycle as a wrong `rdData`, `irqPending` or sticky flag, and the timeout window is measured in clock cycles from request to `done`.

// File: rtl/dclink_pkg.sv
package dclink_pkg;
  localparam int OP_W    = 3;
  localparam int ID_W    = 4;
  localparam int PAY_W   = 9;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 24;
  localparam int FRAME_W = OP_W + ID_W + PAY_W;
  localparam int CRC_W   = 5;
  localparam int LINE_W  = FRAME_W + CRC_W + 2;
  localparam logic [CRC_W-1:0] CRC_POLY = 5'h05;
  localparam logic [CRC_W-1:0] CRC_SEED = 5'h1F;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 3'd0,
    OP_ADDR_HI = 3'd1,
    OP_ADDR_LO = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4,
    OP_STATUS  = 3'd5
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               loadTx;
    logic               armRx;
    logic [FRAME_W-1:0] txWord;
  } dpCtrl_t;

  // events from datapath to control
  typedef struct packed {
    logic              txDone;
    logic              rxDone;
    logic              rxGood;
    logic              rxTimeout;
    logic              rxIrq;
    logic [DATA_W-1:0] rxData;
  } dpStat_t;

  function automatic logic [CRC_W-1:0] crc5(input logic [FRAME_W-1:0] word);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = CRC_SEED;
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ word[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    return acc;
  endfunction
endpackage

// File: rtl/dclink_datapath.sv
module dclink_datapath
  import dclink_pkg::*;
#(
  parameter int DIV_W        = 16,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  dpCtrl_t          ctrl,
  output dpStat_t          stat,
  output logic             txLine,
  input  logic             rxLine
);
  localparam int BIT_CW = $clog2(LINE_W);
  localparam int TO_W   = $clog2(TIMEOUT_BITS + 1);

  typedef enum logic [1:0] {DP_IDLE, DP_TX, DP_HUNT, DP_RX} dpState_e;

  dpState_e           state;
  logic [DIV_W-1:0]   baudCnt;
  logic [BIT_CW-1:0]  bitCnt;
  logic [TO_W-1:0]    waitCnt;
  logic [LINE_W-1:0]  txShift;
  logic [LINE_W-1:0]  rxShift;
  logic               rxMeta, rxSync;
  logic               txDoneQ, rxDoneQ, rxGoodQ, rxTimeoutQ, rxIrqQ;
  logic [DATA_W-1:0]  rxDataQ;

  logic               tick;
  logic [DIV_W-1:0]   halfDiv, startOffset;
  logic [LINE_W-1:0]  rxFull;
  logic [FRAME_W-1:0] rxWord;
  logic [CRC_W-1:0]   rxCrc;

  assign tick        = (baudCnt == '0);
  assign halfDiv     = clkDiv >> 1;
  // the two-flop synchronizer adds latency; pull the sample point back
  assign startOffset = (halfDiv >= DIV_W'(2)) ? halfDiv - DIV_W'(2) : '0;
  assign rxFull      = {rxShift[LINE_W-2:0], rxSync};
  assign rxWord      = rxFull[LINE_W-2 -: FRAME_W];
  assign rxCrc       = rxFull[CRC_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= DP_IDLE;
      baudCnt    <= '0;
      bitCnt     <= '0;
      waitCnt    <= '0;
      txShift    <= '1;
      rxShift    <= '0;
      rxMeta     <= 1'b1;
      rxSync     <= 1'b1;
      txDoneQ    <= 1'b0;
      rxDoneQ    <= 1'b0;
      rxGoodQ    <= 1'b0;
      rxTimeoutQ <= 1'b0;
      rxIrqQ     <= 1'b0;
      rxDataQ    <= '0;
    end else begin
      rxMeta     <= rxLine;
      rxSync     <= rxMeta;
      txDoneQ    <= 1'b0;
      rxDoneQ    <= 1'b0;
      rxTimeoutQ <= 1'b0;
      if (state != DP_IDLE) baudCnt <= tick ? clkDiv : baudCnt - DIV_W'(1);
      unique case (state)
        DP_IDLE: begin
          if (ctrl.loadTx) begin
            txShift <= {1'b0, ctrl.txWord, crc5(ctrl.txWord), 1'b1};
            bitCnt  <= BIT_CW'(LINE_W - 1);
            baudCnt <= clkDiv;
            state   <= DP_TX;
          end else if (ctrl.armRx) begin
            waitCnt <= '0;
            baudCnt <= clkDiv;
            state   <= DP_HUNT;
          end
        end
        DP_TX: begin
          if (tick) begin
            if (bitCnt == '0) begin
              state   <= DP_IDLE;
              txDoneQ <= 1'b1;
            end else begin
              txShift <= {txShift[LINE_W-2:0], 1'b1};
              bitCnt  <= bitCnt - BIT_CW'(1);
            end
          end
        end
        DP_HUNT: begin
          if (!rxSync) begin
            state   <= DP_RX;
            baudCnt <= startOffset;
            bitCnt  <= BIT_CW'(LINE_W - 1);
          end else if (tick) begin
            if (waitCnt == TO_W'(TIMEOUT_BITS - 1)) begin
              state      <= DP_IDLE;
              rxTimeoutQ <= 1'b1;
            end else begin
              waitCnt <= waitCnt + TO_W'(1);
            end
          end
        end
        DP_RX: begin
          if (tick) begin
            rxShift <= rxFull;
            if (bitCnt == '0) begin
              state   <= DP_IDLE;
              rxDoneQ <= 1'b1;
              rxGoodQ <= !rxFull[LINE_W-1] && rxFull[0] && (crc5(rxWord) == rxCrc);
              rxIrqQ  <= rxWord[FRAME_W-1];
              rxDataQ <= rxWord[DATA_W-1:0];
            end else begin
              bitCnt <= bitCnt - BIT_CW'(1);
            end
          end
        end
        default: state <= DP_IDLE;
      endcase
    end
  end

  assign txLine = (state == DP_TX) ? txShift[LINE_W-1] : 1'b1;

  assign stat = '{txDone: txDoneQ, rxDone: rxDoneQ, rxGood: rxGoodQ,
                  rxTimeout: rxTimeoutQ, rxIrq: rxIrqQ, rxData: rxDataQ};

  // control may only strobe the datapath while it is idle
  assert_no_strobe_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state != DP_IDLE) |-> !(ctrl.loadTx || ctrl.armRx));

  // a finished command frame always ends on the idle (stop) level
  assert_stop_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    txDoneQ |-> txLine);
endmodule

// File: rtl/dclink_ctrl.sv
module dclink_ctrl
  import dclink_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic [1:0]        reqKind,
  input  logic [ID_W-1:0]   reqSlave,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              errClear,
  output logic              busy,
  output logic              done,
  output logic              xferOk,
  output logic [DATA_W-1:0] rdData,
  output logic              errCrc,
  output logic              errTimeout,
  output logic              irqPending,
  output dpCtrl_t           dpCtrl,
  input  dpStat_t           dpStat
);
  localparam int TAG_W = ADDR_W - DATA_W;

  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_TXWAIT, C_RXWAIT} cState_e;
  typedef enum logic [2:0] {ST_HI, ST_MID, ST_LO, ST_DATA, ST_STAT} step_e;
  typedef enum logic [1:0] {K_READ, K_WRITE, K_STATUS} kind_e;

  cState_e           state;
  step_e             step;
  kind_e             kindQ;
  logic [ID_W-1:0]   slaveQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ;
  logic              cacheValid;
  logic [ID_W-1:0]   cacheSlave;
  logic [TAG_W-1:0]  cacheTag;

  kind_e             reqKindDec;
  logic              reuseHit;
  opcode_e           txOp;
  logic [PAY_W-1:0]  txPay;
  logic              lastStep;

  always_comb begin
    unique case (reqKind)
      2'd0:    reqKindDec = K_READ;
      2'd1:    reqKindDec = K_WRITE;
      default: reqKindDec = K_STATUS;
    endcase
  end

  assign reuseHit = cacheValid && (reqSlave == cacheSlave) &&
                    (reqAddr[ADDR_W-1:DATA_W] == cacheTag);
  assign lastStep = (step == ST_DATA) || (step == ST_STAT);

  always_comb begin
    unique case (step)
      ST_HI:   begin txOp = OP_ADDR_HI; txPay = {1'b0, addrQ[ADDR_W-1 -: DATA_W]}; end
      ST_MID:  begin txOp = OP_ADDR_LO; txPay = {1'b0, addrQ[2*DATA_W-1 -: DATA_W]}; end
      ST_LO:   begin txOp = OP_ADDR_LO; txPay = {1'b1, addrQ[DATA_W-1:0]}; end
      ST_DATA: begin
        if (kindQ == K_WRITE) begin txOp = OP_WRITE; txPay = {1'b0, wdQ}; end
        else                  begin txOp = OP_READ;  txPay = '0; end
      end
      default: begin txOp = OP_STATUS; txPay = '0; end
    endcase
  end

  assign dpCtrl = '{loadTx: (state == C_ISSUE),
                    armRx:  (state == C_TXWAIT) && dpStat.txDone,
                    txWord: {txOp, slaveQ, txPay}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= C_IDLE;
      step       <= ST_STAT;
      kindQ      <= K_STATUS;
      slaveQ     <= '0;
      addrQ      <= '0;
      wdQ        <= '0;
      cacheValid <= 1'b0;
      cacheSlave <= '0;
      cacheTag   <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      xferOk     <= 1'b0;
      rdData     <= '0;
      errCrc     <= 1'b0;
      errTimeout <= 1'b0;
      irqPending <= 1'b0;
    end else begin
      done <= 1'b0;
      if (errClear) begin
        errCrc     <= 1'b0;
        errTimeout <= 1'b0;
      end
      unique case (state)
        C_IDLE: begin
          if (reqStart) begin
            kindQ  <= reqKindDec;
            slaveQ <= reqSlave;
            addrQ  <= reqAddr;
            wdQ    <= reqWrData;
            if (reqKindDec == K_STATUS) step <= ST_STAT;
            else                        step <= reuseHit ? ST_LO : ST_HI;
            busy   <= 1'b1;
            state  <= C_ISSUE;
          end
        end
        C_ISSUE:  state <= C_TXWAIT;
        C_TXWAIT: if (dpStat.txDone) state <= C_RXWAIT;
        C_RXWAIT: begin
          if (dpStat.rxTimeout) begin
            errTimeout <= 1'b1;
            cacheValid <= 1'b0;
            xferOk     <= 1'b0;
            done       <= 1'b1;
            busy       <= 1'b0;
            state      <= C_IDLE;
          end else if (dpStat.rxDone) begin
            if (!dpStat.rxGood) begin
              errCrc     <= 1'b1;
              cacheValid <= 1'b0;
              xferOk     <= 1'b0;
              done       <= 1'b1;
              busy       <= 1'b0;
              state      <= C_IDLE;
            end else begin
              irqPending <= dpStat.rxIrq;
              if (lastStep) begin
                if (kindQ != K_WRITE) rdData <= dpStat.rxData;
                if (kindQ != K_STATUS) begin
                  cacheValid <= 1'b1;
                  cacheSlave <= slaveQ;
                  cacheTag   <= addrQ[ADDR_W-1:DATA_W];
                end
                xferOk <= 1'b1;
                done   <= 1'b1;
                busy   <= 1'b0;
                state  <= C_IDLE;
              end else begin
                step  <= step_e'(step + 3'd1);
                state <= C_ISSUE;
              end
            end
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dpStat.rxDone && dpStat.rxGood) |=> (irqPending == $past(dpStat.rxIrq)));

  assert_crc_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dpStat.rxDone && !dpStat.rxGood) |=> (errCrc && done && !xferOk));

  assert_crc_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errCrc && !errClear) |=> errCrc);

  assert_timeout_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    dpStat.rxTimeout |=> (errTimeout && done && !xferOk));
endmodule

// File: rtl/dclink_master.sv
module dclink_master
  import dclink_pkg::*;
#(
  parameter int DIV_W        = 16,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              reqStart,
  input  logic [1:0]        reqKind,
  input  logic [ID_W-1:0]   reqSlave,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              errClear,
  output logic              busy,
  output logic              done,
  output logic              xferOk,
  output logic [DATA_W-1:0] rdData,
  output logic              errCrc,
  output logic              errTimeout,
  output logic              irqPending,
  output logic              txLine,
  input  logic              rxLine
);
  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  dclink_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqStart(reqStart), .reqKind(reqKind), .reqSlave(reqSlave),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .errClear(errClear),
    .busy(busy), .done(done), .xferOk(xferOk), .rdData(rdData),
    .errCrc(errCrc), .errTimeout(errTimeout), .irqPending(irqPending),
    .dpCtrl(dpCtrl), .dpStat(dpStat)
  );

  dclink_datapath #(.DIV_W(DIV_W), .TIMEOUT_BITS(TIMEOUT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv),
    .ctrl(dpCtrl), .stat(dpStat),
    .txLine(txLine), .rxLine(rxLine)
  );
endmodule

// File: tb/dclink_master_tb.sv
module dclink_master_tb;
  localparam int TO_BITS = 32;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  slave;
    logic [23:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic        irq;
    logic [1:0]  fault;   // 0 none, 1 corrupt first reply, 2 no first reply
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{2'd0, 4'd3, 24'h123456, 8'h00, 8'hA5, 1'b0, 2'd0},
    '{2'd0, 4'd3, 24'h123478, 8'h00, 8'h3C, 1'b1, 2'd0},
    '{2'd1, 4'd3, 24'h123479, 8'h5A, 8'h00, 1'b0, 2'd0},
    '{2'd1, 4'd5, 24'h123479, 8'hC3, 8'h00, 1'b0, 2'd0},
    '{2'd2, 4'd9, 24'h000000, 8'h00, 8'h81, 1'b1, 2'd0},
    '{2'd0, 4'd5, 24'h123480, 8'h00, 8'h11, 1'b0, 2'd1},
    '{2'd0, 4'd5, 24'h123481, 8'h00, 8'h77, 1'b0, 2'd0},
    '{2'd0, 4'd5, 24'h123482, 8'h00, 8'h99, 1'b1, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] clkDiv = 16'd7;
  logic        reqStart = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [3:0]  reqSlave = 4'd0;
  logic [23:0] reqAddr = 24'd0;
  logic [7:0]  reqWrData = 8'd0;
  logic        errClear = 1'b0;
  logic        busy, done, xferOk, errCrc, errTimeout, irqPending, txLine;
  logic [7:0]  rdData;
  logic        rxLine = 1'b1;

  int testCount = 0, failCount = 0, cycles = 0;
  int tbDiv = 7;
  int fault = 0;
  logic [7:0]  cfgData = 8'h00;
  logic        cfgIrq = 1'b0;
  logic [15:0] logWord [0:7];
  logic        logOk [0:7];
  int          logCount = 0;
  logic        measArm = 1'b0;
  int          measLen = 0;

  always #10 clk = ~clk;

  dclink_master u_dut (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .reqStart(reqStart),
    .reqKind(reqKind), .reqSlave(reqSlave), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .errClear(errClear), .busy(busy), .done(done),
    .xferOk(xferOk), .rdData(rdData), .errCrc(errCrc),
    .errTimeout(errTimeout), .irqPending(irqPending),
    .txLine(txLine), .rxLine(rxLine)
  );

  function automatic logic [4:0] tbCrc(input logic [15:0] w);
    logic [4:0] r;
    logic b;
    r = 5'b11111;
    for (int i = 15; i >= 0; i--) begin
      b = r[4] ^ w[i];
      r = {r[3:0], 1'b0} ^ (b ? 5'b00101 : 5'b00000);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model: decode a command, answer after a gap
  task automatic recvFrame(output logic [15:0] w, output logic ok);
    logic [22:0] bits;
    repeat ((tbDiv + 1) / 2) @(negedge clk);
    bits[22] = txLine;
    for (int i = 21; i >= 0; i--) begin
      repeat (tbDiv + 1) @(negedge clk);
      bits[i] = txLine;
    end
    w  = bits[21:6];
    ok = !bits[22] && bits[0] && (bits[5:1] == tbCrc(bits[21:6]));
  endtask

  task automatic sendFrame(input logic [15:0] w, input logic [4:0] c);
    logic [22:0] bits;
    bits = {1'b0, w, c, 1'b1};
    for (int i = 22; i >= 1; i--) begin
      rxLine = bits[i];
      repeat (tbDiv + 1) @(negedge clk);
    end
    rxLine = 1'b1;
  endtask

  initial begin
    logic [15:0] w, reply;
    logic ok;
    logic [4:0] c;
    int n;
    forever begin
      @(negedge clk);
      if (rstN && txLine === 1'b0) begin
        recvFrame(w, ok);
        if (logCount < 8) begin
          logWord[logCount] = w;
          logOk[logCount]   = ok;
        end
        logCount++;
        n = logCount;
        if (!(fault == 2 && n == 1)) begin
          repeat (3 * (tbDiv + 1)) @(negedge clk);
          reply = {cfgIrq, w[12:9], 3'b000,
                   (w[15:13] == 3'd4 || w[15:13] == 3'd5) ? cfgData : 8'h00};
          c = tbCrc(reply);
          if (fault == 1 && n == 1) c = c ^ 5'h01;
          sendFrame(reply, c);
        end
      end
    end
  end

  // start-bit length monitor for the bit period check
  initial begin
    int run;
    run = 0;
    forever begin
      @(negedge clk);
      if (txLine === 1'b0) run++;
      else begin
        if (run > 0 && measArm) begin
          measLen = run;
          measArm = 1'b0;
        end
        run = 0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failCount++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", testCount, failCount);
        $finish;
      end
    end
  end

  task automatic runXfer(input logic [1:0] k, input logic [3:0] s, input logic [23:0] a,
                         input logic [7:0] wd, output int cyc);
    @(negedge clk);
    reqKind = k; reqSlave = s; reqAddr = a; reqWrData = wd; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R12 done seen", {31'd0, done}, 32'd1);
  endtask

  function automatic logic [15:0] expWord(input vec_t v, input int idx, input bit hit);
    int st;
    st = hit ? idx + 2 : idx;
    if (v.kind >= 2) return {3'd5, v.slave, 9'd0};
    case (st)
      0: return {3'd1, v.slave, 1'b0, v.addr[23:16]};
      1: return {3'd2, v.slave, 1'b0, v.addr[15:8]};
      2: return {3'd2, v.slave, 1'b1, v.addr[7:0]};
      default: return (v.kind == 2'd1) ? {3'd3, v.slave, 1'b0, v.wd} : {3'd4, v.slave, 9'd0};
    endcase
  endfunction

  initial begin
    bit mValid, hit, expCrc, expTo, expIrq;
    logic [3:0] mSlave;
    logic [15:0] mTag;
    logic [7:0] expRd;
    int nExp, cyc;
    mValid = 0; mSlave = 0; mTag = 0; expRd = 0;
    expCrc = 0; expTo = 0; expIrq = 0;

    repeat (3) @(negedge clk);
    // R13 reset state
    chk(txLine === 1'b1, "R13 txLine idle", {31'd0, txLine}, 32'd1);
    chk(busy === 1'b0 && done === 1'b0, "R13 busy/done", {30'd0, busy, done}, 32'd0);
    chk(errCrc === 1'b0 && errTimeout === 1'b0, "R13 errors", {30'd0, errCrc, errTimeout}, 32'd0);
    chk(irqPending === 1'b0 && rdData === 8'h00, "R13 irq/rdData", {23'd0, irqPending, rdData}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      hit = (v.kind < 2) && mValid && (v.slave == mSlave) && (v.addr[23:8] == mTag);
      nExp = (v.kind >= 2) ? 1 : (hit ? 2 : 4);
      if (v.fault != 0) nExp = 1;
      cfgData = v.rd; cfgIrq = v.irq; fault = int'(v.fault); logCount = 0;
      runXfer(v.kind, v.slave, v.addr, v.wd, cyc);
      chk(logCount == nExp, $sformatf("R4 R5 R6 frame count vec%0d", i), logCount, nExp);
      for (int f = 0; f < 8; f++) begin
        if (f < nExp && f < logCount) begin
          chk(logWord[f] == expWord(v, f, hit), $sformatf("R4 R5 R6 R1 frame word vec%0d.%0d", i, f),
              {16'd0, logWord[f]}, {16'd0, expWord(v, f, hit)});
          chk(logOk[f] === 1'b1, $sformatf("R2 R1 frame crc/stop vec%0d.%0d", i, f), {31'd0, logOk[f]}, 32'd1);
        end
      end
      if (v.fault == 0) begin
        if (v.kind != 2'd1) expRd = v.rd;
        expIrq = v.irq;
        if (v.kind < 2) begin mValid = 1; mSlave = v.slave; mTag = v.addr[23:8]; end
      end else begin
        mValid = 0;
        if (v.fault == 1) expCrc = 1; else expTo = 1;
      end
      chk(xferOk === (v.fault == 0), $sformatf("R12 xferOk vec%0d", i), {31'd0, xferOk}, {31'd0, v.fault == 0});
      chk(rdData === expRd, $sformatf("R7 rdData vec%0d", i), {24'd0, rdData}, {24'd0, expRd});
      chk(irqPending === expIrq, $sformatf("R8 irqPending vec%0d", i), {31'd0, irqPending}, {31'd0, expIrq});
      chk(errCrc === expCrc, $sformatf("R9 errCrc vec%0d", i), {31'd0, errCrc}, {31'd0, expCrc});
      chk(errTimeout === expTo, $sformatf("R10 errTimeout vec%0d", i), {31'd0, errTimeout}, {31'd0, expTo});
      if (v.fault == 2) begin
        nExp = 3 + 23 * (tbDiv + 1) + TO_BITS * (tbDiv + 1) + 1;
        chk(cyc >= nExp - 4 && cyc <= nExp + 4, "R10 timeout window", cyc, nExp);
      end
      @(negedge clk);
      chk(done === 1'b0, $sformatf("R12 done one cycle vec%0d", i), {31'd0, done}, 32'd0);
      fault = 0;
      repeat (40) @(negedge clk);
    end

    // R11 clear sticky flags
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    chk(errCrc === 1'b0 && errTimeout === 1'b0, "R11 clear", {30'd0, errCrc, errTimeout}, 32'd0);

    // R3 bit period at another divider, status frame starts 0 then 1
    tbDiv = 11; clkDiv = 16'd11; cfgData = 8'h4E; cfgIrq = 1'b0; logCount = 0; measArm = 1'b1;
    runXfer(2'd2, 4'd0, 24'd0, 8'd0, cyc);
    chk(measLen == 12, "R3 start bit length", measLen, 12);
    chk(logCount == 1 && logOk[0] === 1'b1 && logWord[0] == 16'hA000, "R3 R6 frame at new divider",
        {16'd0, logWord[0]}, 32'h0000A000);
    chk(rdData === 8'h4E && irqPending === 1'b0, "R7 R8 status at new divider", {23'd0, irqPending, rdData}, 32'h4E);
    repeat (40) @(negedge clk);

    // R12 second request while busy is ignored; R5 reuse after timeout cleared cache
    tbDiv = 7; clkDiv = 16'd7; cfgData = 8'h6D; logCount = 0;
    @(negedge clk);
    reqKind = 2'd0; reqSlave = 4'd3; reqAddr = 24'h123490; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy === 1'b1, "R12 busy during request", {31'd0, busy}, 32'd1);
    reqKind = 2'd2; reqSlave = 4'd9; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1 && rdData === 8'h6D, "R12 R7 first request result", {24'd0, rdData}, 32'h6D);
    repeat (600) @(negedge clk);
    chk(logCount == 4, "R12 R5 no extra frames", logCount, 4);
    chk(logWord[3] == {3'd4, 4'd3, 9'd0}, "R12 slave of last frame", {16'd0, logWord[3]}, {16'd0, 3'd4, 4'd3, 9'd0});
    chk(busy === 1'b0 && errCrc === 1'b0 && errTimeout === 1'b0, "R12 idle after", {29'd0, busy, errCrc, errTimeout}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule